// File: doc/BRIEF.md
# Dual Q15 Fractional Multiply Unit

This block is the two-lane signed multiply stage of a DSP register-file extension. Each 32-bit source word holds two signed 16-bit halves. The halves are paired across the two sources by a 2-bit pairing field, and two 32-bit products are formed. There are three variants. The plain variant writes the raw products. In the two fractional variants, each product is doubled into Q31 format and may be rounded. The split variant writes both lane results to two destinations. The packed variant merges the two upper halves into a single word.

The caller presents an instruction word, the two source operands and the rounding-control word, and pulses `start` for one cycle. One clock later the block presents its write-back: which ports write, the destination indices and the data. If a fractional sub-opcode has no assigned meaning, the block flags it as reserved and suppresses all writes. Register storage, saturation and accumulation are handled elsewhere.

Top module: `q15_dual_mul`

## Requirements
- R1: After reset, `done`, `reserved`, `wr_a_en` and `wr_b_en` are low. A `start` pulse makes `done` high for exactly the next cycle, carrying that operation's results. In any cycle that does not follow a `start`, all of these outputs are low.
- R2: Each source is split into a high half (bits 31:16) and a low half (bits 15:0), and each half is sign-extended. The pairing field `insn[23:22]` selects, as (first source half × second source half) for lane 1 then lane 2: 0 = H×H, L×L; 1 = L×H, L×L; 2 = H×H, H×L; 3 = L×H, H×L.
- R3: With `frac_grp` = 0 (plain variant, `insn[25:24]` ignored), lane 1's product goes to port A and lane 2's product goes to port B. Both ports write, and there is no doubling or rounding.
- R4: With `frac_grp` = 1, each product is shifted left by one bit. If `ctrl[1]` = 0, the shifted values are used unchanged.
- R5: The split fractional variant (`frac_grp` = 1, `insn[25:24]` = 1) writes lane 1 to port A and lane 2 to port B. When `ctrl[1]` = 1 it adds 0x8000 to each lane, whatever the value of `ctrl[2]`.
- R6: The packed variant (`frac_grp` = 1, `insn[25:24]` = 0) with `ctrl[1]` = 1 and `ctrl[2]` = 1 adds 0x8000 to every lane.
- R7: The packed variant with `ctrl[1]` = 1 and `ctrl[2]` = 0 adds 0x8000 to a lane unless bits 16:0 of that doubled lane equal exactly 0x08000. This rounds halves to even.
- R8: The packed variant writes port A only. Bits 31:16 hold lane 1 bits 31:16, and bits 15:0 hold lane 2 bits 31:16. `wr_b_en` stays low.
- R9: With `frac_grp` = 1 and `insn[25:24]` equal to 2 or 3, `reserved` is high with `done` and neither port writes.
- R10: Port A's index is `insn[9:6]` and port B's index is `insn[21:18]`. Other instruction bits are ignored.
- R11: Doubling and rounding wrap modulo 2^32 without saturation. For example, −32768 × −32768 doubles to 0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation strobe |
| frac_grp | input | 1 | 1 = fractional group (sub-opcode decoded), 0 = plain multiply |
| insn | input | 32 | Instruction word holding indices, pairing and sub-opcode |
| src_a | input | 32 | First source operand (two signed halves) |
| src_b | input | 32 | Second source operand (two signed halves) |
| ctrl | input | 32 | Control word; bit 1 enables rounding, bit 2 forces the bias |
| done | output | 1 | Result valid, one cycle after start |
| reserved | output | 1 | Unassigned fractional sub-opcode |
| wr_a_en | output | 1 | Write enable, destination A |
| wr_a_idx | output | 4 | Destination A index |
| wr_a_data | output | 32 | Destination A data |
| wr_b_en | output | 1 | Write enable, destination B |
| wr_b_idx | output | 4 | Destination B index |
| wr_b_data | output | 32 | Destination B data |

## Verification
The datapath is combinational into one output register, so every result is due at the first rising edge after the edge that samples `start`, and it is gone one edge later. The bench drives each operation on a falling edge and holds `start` for one period. It compares every output on the next falling edge, half a period after the results are registered. One falling edge later it confirms that `done` and both write enables have dropped. The round-to-even cases use products whose doubled low 17 bits sit exactly on the tie, with both an even and an odd upper half.

// File: rtl/q15m_pkg.sv
package q15m_pkg;

    localparam int WORD_W   = 32;
    localparam int HALF_W   = 16;
    localparam int IDX_W    = 4;
    localparam int LANES    = 2;

    // instruction field positions
    localparam int SUB_LSB  = 24;
    localparam int PAIR_LSB = 22;
    localparam int IDXB_LSB = 18;
    localparam int IDXA_LSB = 6;

    // control word bits
    localparam int CTRL_RND_BIT  = 1;
    localparam int CTRL_BIAS_BIT = 2;

    localparam logic [WORD_W-1:0] RND_ADD  = WORD_W'(1) << (HALF_W - 1);
    localparam logic [HALF_W:0]   TIE_PAT  = (HALF_W + 1)'(1) << (HALF_W - 1);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [HALF_W-1:0] half_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef enum logic [1:0] {
        K_PLAIN  = 2'd0,
        K_PACKED = 2'd1,
        K_SPLIT  = 2'd2,
        K_BAD    = 2'd3
    } kind_e;

    typedef struct packed {
        kind_e      kind;
        logic [1:0] pair;
        idx_t       idx_a;
        idx_t       idx_b;
    } op_t;

    typedef struct packed {
        logic rnd_on;
        logic force_bias;
    } rnd_cfg_t;

    function automatic word_t sext_half(input half_t h);
        return {{(WORD_W - HALF_W){h[HALF_W-1]}}, h};
    endfunction

    // rounding of a doubled lane value; wraps modulo 2^WORD_W
    function automatic word_t round_lane(input word_t dbl, input kind_e k,
                                         input rnd_cfg_t c);
        if (!c.rnd_on)
            return dbl;
        if (k != K_PACKED || c.force_bias)
            return dbl + RND_ADD;
        if (dbl[HALF_W:0] == TIE_PAT)
            return dbl;
        return dbl + RND_ADD;
    endfunction

endpackage

// File: rtl/q15m_decode.sv
module q15m_decode
    import q15m_pkg::*;
(
    input  logic  frac_grp,
    input  word_t insn,
    output op_t   op
);
    logic [1:0] sub;
    logic       unused_insn;

    assign sub         = insn[SUB_LSB +: 2];
    assign unused_insn = ^{insn[WORD_W-1:SUB_LSB+2],
                           insn[IDXB_LSB-1:IDXA_LSB+IDX_W],
                           insn[IDXA_LSB-1:0]};

    always_comb begin
        op.pair  = insn[PAIR_LSB +: 2];
        op.idx_a = insn[IDXA_LSB +: IDX_W];
        op.idx_b = insn[IDXB_LSB +: IDX_W];
        if (!frac_grp) begin
            op.kind = K_PLAIN;
        end else begin
            unique case (sub)
                2'd0:    op.kind = K_PACKED;
                2'd1:    op.kind = K_SPLIT;
                default: op.kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/q15m_lane.sv
module q15m_lane
    import q15m_pkg::*;
(
    input  half_t    a_hi,
    input  half_t    a_lo,
    input  half_t    b_half,
    input  logic     pick_lo,
    input  kind_e    kind,
    input  rnd_cfg_t cfg,
    output word_t    res
);
    word_t a_ext;
    word_t b_ext;
    word_t prod;
    word_t dbl;

    assign a_ext = sext_half(pick_lo ? a_lo : a_hi);
    assign b_ext = sext_half(b_half);
    assign prod  = a_ext * b_ext;
    assign dbl   = prod << 1;

    always_comb begin
        if (kind == K_PLAIN)
            res = prod;
        else
            res = round_lane(dbl, kind, cfg);
    end
endmodule

// File: rtl/q15m_pack.sv
module q15m_pack
    import q15m_pkg::*;
(
    input  kind_e kind,
    input  word_t lane0,
    input  word_t lane1,
    output logic  bad,
    output logic  a_en,
    output logic  b_en,
    output word_t a_data,
    output word_t b_data
);
    always_comb begin
        bad    = 1'b0;
        a_en   = 1'b1;
        b_en   = 1'b1;
        a_data = lane0;
        b_data = lane1;
        unique case (kind)
            K_PACKED: begin
                b_en   = 1'b0;
                a_data = {lane0[WORD_W-1:HALF_W], lane1[WORD_W-1:HALF_W]};
                b_data = '0;
            end
            K_BAD: begin
                bad    = 1'b1;
                a_en   = 1'b0;
                b_en   = 1'b0;
                a_data = '0;
                b_data = '0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/q15_dual_mul.sv
module q15_dual_mul
    import q15m_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              frac_grp,
    input  logic [31:0]       insn,
    input  logic [31:0]       src_a,
    input  logic [31:0]       src_b,
    input  logic [31:0]       ctrl,
    output logic              done,
    output logic              reserved,
    output logic              wr_a_en,
    output logic [3:0]        wr_a_idx,
    output logic [31:0]       wr_a_data,
    output logic              wr_b_en,
    output logic [3:0]        wr_b_idx,
    output logic [31:0]       wr_b_data
);
    op_t      op;
    rnd_cfg_t cfg;
    word_t    lane_res [LANES];
    logic     bad_c, a_en_c, b_en_c;
    word_t    a_data_c, b_data_c;
    logic     unused_ctrl;

    assign cfg.rnd_on     = ctrl[CTRL_RND_BIT];
    assign cfg.force_bias = ctrl[CTRL_BIAS_BIT];
    assign unused_ctrl    = ^{ctrl[WORD_W-1:CTRL_BIAS_BIT+1],
                              ctrl[CTRL_RND_BIT-1:0]};

    q15m_decode u_dec (
        .frac_grp (frac_grp),
        .insn     (insn),
        .op       (op)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        half_t b_sel;
        logic  pick;
        if (l == 0) begin : g_first
            assign b_sel = src_b[WORD_W-1:HALF_W];
            assign pick  = op.pair[0];
        end else begin : g_second
            assign b_sel = src_b[HALF_W-1:0];
            assign pick  = ~op.pair[1];
        end
        q15m_lane u_lane (
            .a_hi    (src_a[WORD_W-1:HALF_W]),
            .a_lo    (src_a[HALF_W-1:0]),
            .b_half  (b_sel),
            .pick_lo (pick),
            .kind    (op.kind),
            .cfg     (cfg),
            .res     (lane_res[l])
        );
    end

    q15m_pack u_pack (
        .kind   (op.kind),
        .lane0  (lane_res[0]),
        .lane1  (lane_res[1]),
        .bad    (bad_c),
        .a_en   (a_en_c),
        .b_en   (b_en_c),
        .a_data (a_data_c),
        .b_data (b_data_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            reserved  <= 1'b0;
            wr_a_en   <= 1'b0;
            wr_b_en   <= 1'b0;
            wr_a_idx  <= '0;
            wr_b_idx  <= '0;
            wr_a_data <= '0;
            wr_b_data <= '0;
        end else begin
            done     <= start;
            reserved <= start & bad_c;
            wr_a_en  <= start & a_en_c;
            wr_b_en  <= start & b_en_c;
            if (start) begin
                wr_a_idx  <= op.idx_a;
                wr_b_idx  <= op.idx_b;
                wr_a_data <= a_data_c;
                wr_b_data <= b_data_c;
            end
        end
    end
endmodule

// File: rtl/q15m_checker.sv
module q15m_checker
    import q15m_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        frac_grp,
    input logic [31:0] insn,
    input logic        done,
    input logic        reserved,
    input logic        wr_a_en,
    input logic        wr_b_en
);
    logic [1:0] sub;
    assign sub = insn[SUB_LSB +: 2];

    a_r1_done_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> done);

    a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!done && !reserved && !wr_a_en && !wr_b_en));

    a_r3_plain_writes_both: assert property (@(posedge clk) disable iff (rst)
        (start && !frac_grp) |=> (wr_a_en && wr_b_en && !reserved));

    a_r5_split_writes_both: assert property (@(posedge clk) disable iff (rst)
        (start && frac_grp && sub == 2'd1) |=> (wr_a_en && wr_b_en));

    a_r8_packed_single_dest: assert property (@(posedge clk) disable iff (rst)
        (start && frac_grp && sub == 2'd0) |=> (wr_a_en && !wr_b_en));

    a_r9_reserved_flagged: assert property (@(posedge clk) disable iff (rst)
        (start && frac_grp && sub[1]) |=> reserved);

    a_r9_reserved_no_write: assert property (@(posedge clk) disable iff (rst)
        reserved |-> (!wr_a_en && !wr_b_en && done));
endmodule

bind q15_dual_mul q15m_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .frac_grp (frac_grp),
    .insn     (insn),
    .done     (done),
    .reserved (reserved),
    .wr_a_en  (wr_a_en),
    .wr_b_en  (wr_b_en)
);

// File: tb/q15_dual_mul_bench.sv
`timescale 1ns/1ps
module q15_dual_mul_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        frac_grp = 1'b0;
    logic [31:0] insn = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] ctrl = '0;
    logic        done, reserved, wr_a_en, wr_b_en;
    logic [3:0]  wr_a_idx, wr_b_idx;
    logic [31:0] wr_a_data, wr_b_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    q15_dual_mul u_q15_dual_mul (
        .clk(clk), .rst(rst), .start(start), .frac_grp(frac_grp),
        .insn(insn), .src_a(src_a), .src_b(src_b), .ctrl(ctrl),
        .done(done), .reserved(reserved),
        .wr_a_en(wr_a_en), .wr_a_idx(wr_a_idx), .wr_a_data(wr_a_data),
        .wr_b_en(wr_b_en), .wr_b_idx(wr_b_idx), .wr_b_data(wr_b_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // independent model of one lane per the requirements
    function automatic logic [31:0] mdl_lane(input int lane, input logic [31:0] a,
            input logic [31:0] b, input logic [1:0] pair, input bit frac,
            input bit pk, input logic [31:0] c);
        int ah = $signed(a[31:16]);
        int al = $signed(a[15:0]);
        int bh = $signed(b[31:16]);
        int bl = $signed(b[15:0]);
        int x;
        int y;
        logic [31:0] p;
        if (lane == 0) begin
            x = pair[0] ? al : ah;
            y = bh;
        end else begin
            x = pair[1] ? ah : al;
            y = bl;
        end
        p = x * y;
        if (!frac) return p;
        p = p << 1;
        if (!c[1]) return p;
        if (!pk || c[2]) return p + 32'h8000;
        if (p[16:0] == 17'h08000) return p;
        return p + 32'h8000;
    endfunction

    // drive one operation, check every output against the model
    task automatic run(input string tag, input bit frac, input logic [1:0] sub,
            input logic [1:0] pair, input logic [3:0] ida, input logic [3:0] idb,
            input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
            output logic [31:0] got_a, output logic [31:0] got_b);
        bit bad, pk;
        logic [31:0] l0, l1, ea;
        bad = frac && sub[1];
        pk  = frac && sub == 2'd0;
        l0  = mdl_lane(0, a, b, pair, frac, pk, c);
        l1  = mdl_lane(1, a, b, pair, frac, pk, c);
        ea  = pk ? {l0[31:16], l1[31:16]} : l0;
        @(negedge clk);
        frac_grp = frac;
        insn  = {6'b0, sub, pair, idb, 8'b0, ida, 6'b0};
        src_a = a;
        src_b = b;
        ctrl  = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R1 done"}, {31'b0, done}, 32'd1);
        chk({tag, " R9 reserved"}, {31'b0, reserved}, {31'b0, bad});
        chk({tag, " R9 wr_a_en"}, {31'b0, wr_a_en}, {31'b0, !bad});
        chk({tag, " R8 wr_b_en"}, {31'b0, wr_b_en}, {31'b0, !bad && !pk});
        if (!bad) begin
            chk({tag, " R10 idx_a"}, {28'b0, wr_a_idx}, {28'b0, ida});
            chk({tag, " R2 data_a"}, wr_a_data, ea);
        end
        if (!bad && !pk) begin
            chk({tag, " R10 idx_b"}, {28'b0, wr_b_idx}, {28'b0, idb});
            chk({tag, " R2 data_b"}, wr_b_data, l1);
        end
        got_a = wr_a_data;
        got_b = wr_b_data;
        @(negedge clk);
        chk({tag, " R1 idle"}, {28'b0, done, reserved, wr_a_en, wr_b_en}, 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 reset done", {31'b0, done}, 32'd0);
        chk("R1 reset writes", {29'b0, reserved, wr_a_en, wr_b_en}, 32'd0);
    endtask

    task automatic t_plain;
        logic [31:0] ga, gb;
        for (int p = 0; p < 4; p++)
            run("plain", 1'b0, 2'd3, 2'(p), 4'd1, 4'd2,
                32'h0003_FFFE, 32'h0005_0007, 32'h6, ga, gb);
        run("plain lit", 1'b0, 2'd0, 2'd0, 4'd1, 4'd2,
            32'h0003_FFFE, 32'h0005_0007, 32'h0, ga, gb);
        chk("R3 plain lane1 3*5", ga, 32'h0000_000F);
        chk("R3 plain lane2 -2*7", gb, 32'hFFFF_FFF2);
    endtask

    task automatic t_pairing;
        logic [31:0] ga, gb;
        run("pair1", 1'b1, 2'd1, 2'd1, 4'd3, 4'd4,
            32'h0002_0003, 32'h0005_0007, 32'h0, ga, gb);
        chk("R2 R4 pair1 lane1 L*H doubled", ga, 32'h0000_001E);
        chk("R2 R4 pair1 lane2 L*L doubled", gb, 32'h0000_002A);
        run("pair3", 1'b1, 2'd1, 2'd3, 4'd3, 4'd4,
            32'h0002_0003, 32'h0005_0007, 32'h0, ga, gb);
        chk("R2 pair3 lane1 L*H", ga, 32'h0000_001E);
        chk("R2 pair3 lane2 H*L", gb, 32'h0000_001C);
    endtask

    task automatic t_split_round;
        logic [31:0] ga, gb;
        run("split rnd", 1'b1, 2'd1, 2'd0, 4'd5, 4'd6,
            32'h0080_0080, 32'h0080_0080, 32'h2, ga, gb);
        chk("R5 split adds bias on tie", ga, 32'h0001_0000);
        run("split rnd bias", 1'b1, 2'd1, 2'd0, 4'd5, 4'd6,
            32'h0080_0080, 32'h0080_0080, 32'h6, ga, gb);
        chk("R5 split ignores ctrl2", gb, 32'h0001_0000);
    endtask

    task automatic t_packed;
        logic [31:0] ga, gb;
        run("pk nornd", 1'b1, 2'd0, 2'd0, 4'd7, 4'd8,
            32'h00C0_0080, 32'h0100_0080, 32'h0, ga, gb);
        chk("R4 R8 packed no rounding", ga, 32'h0001_0000);
        run("pk even", 1'b1, 2'd0, 2'd0, 4'd7, 4'd8,
            32'h00C0_0080, 32'h0100_0080, 32'h2, ga, gb);
        chk("R7 packed round half even", ga, 32'h0002_0000);
        run("pk even tie2", 1'b1, 2'd0, 2'd0, 4'd7, 4'd8,
            32'h0100_0080, 32'h0140_0080, 32'h2, ga, gb);
        chk("R7 even upper tie kept", ga, 32'h0002_0000);
        run("pk bias", 1'b1, 2'd0, 2'd0, 4'd7, 4'd8,
            32'h00C0_0080, 32'h0100_0080, 32'h6, ga, gb);
        chk("R6 packed forced bias", ga, 32'h0002_0001);
    endtask

    task automatic t_reserved;
        logic [31:0] ga, gb;
        run("rsv2", 1'b1, 2'd2, 2'd0, 4'd1, 4'd1,
            32'h1234_5678, 32'h9ABC_DEF0, 32'h6, ga, gb);
        run("rsv3", 1'b1, 2'd3, 2'd2, 4'd1, 4'd1,
            32'h1234_5678, 32'h9ABC_DEF0, 32'h2, ga, gb);
    endtask

    task automatic t_wrap;
        logic [31:0] ga, gb;
        run("wrap nornd", 1'b1, 2'd1, 2'd0, 4'd9, 4'd10,
            32'h8000_8000, 32'h8000_8000, 32'h0, ga, gb);
        chk("R11 doubled wraps", ga, 32'h8000_0000);
        run("wrap split", 1'b1, 2'd1, 2'd0, 4'd9, 4'd10,
            32'h8000_8000, 32'h8000_8000, 32'h2, ga, gb);
        chk("R11 rounded wrap", gb, 32'h8000_8000);
        run("wrap packed", 1'b1, 2'd0, 2'd0, 4'd9, 4'd10,
            32'h8000_8000, 32'h8000_8000, 32'h6, ga, gb);
        chk("R11 packed wrap", ga, 32'h8000_8000);
    endtask

    task automatic t_index;
        logic [31:0] ga, gb;
        run("idx plain", 1'b0, 2'd1, 2'd2, 4'hA, 4'h5,
            32'h7FFF_8001, 32'h8001_7FFF, 32'h0, ga, gb);
        run("idx packed", 1'b1, 2'd0, 2'd1, 4'hF, 4'h0,
            32'h7FFF_8001, 32'h8001_7FFF, 32'h2, ga, gb);
    endtask

    task automatic t_negative;
        logic [31:0] ga, gb;
        for (int p = 0; p < 4; p++) begin
            run("neg split", 1'b1, 2'd1, 2'(p), 4'(p), 4'(p + 4),
                32'hF123_8765, 32'h9ABC_0FED, 32'h2, ga, gb);
            run("neg packed", 1'b1, 2'd0, 2'(p), 4'(p), 4'(p + 4),
                32'hF123_8765, 32'h9ABC_0FED, 32'h2, ga, gb);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_plain();
        t_pairing();
        t_split_round();
        t_packed();
        t_reserved();
        t_wrap();
        t_index();
        t_negative();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule